// File: doc/BRIEF.md
# Dual Up-Counting Timer Pair

This block provides two up-counting timers reached through a small byte-wide register file. The narrow timer fits in a single byte register. The wide timer is twice the data width. Its value passes through a shared low-byte holding buffer, so software can write a full start value, or take a coherent snapshot of the running count, one byte at a time.

Each timer counts edges of a chosen count source. It can use either of two internal tick signals, which are level signals synchronous to the block clock, on the rising or the falling edge. The wide timer can instead count edges from an external pin, which passes through a synchronizer first. A count past all-ones reloads the last start value and sets a sticky overflow flag. Each flag raises the interrupt request unless its mask bit is set.

Top module: `dual_timer`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, both counters read 0x00, the flag register (address 4) reads 0x00, the mask register (address 5) reads 0x03 and `irq` is low.
- R2: Writing a start value (narrow timer at address 1, whole byte) loads both the counter and its preload. While enabled, each selected edge adds one. The edge that finds the count at all-ones reloads the preload and sets the timer's flag (bit 0 narrow, bit 1 wide).
- R3: With the enable bit clear (control bit 0 narrow, bit 4 wide), selected edges leave the count unchanged. Setting the enable again resumes counting from the held value.
- R4: The falling-select bit (control bit 1 narrow, bit 5 wide) at 0 counts rising edges only and at 1 counts falling edges only, one count for each edge.
- R5: The source bit (control bit 2 narrow, bit 6 wide) selects `tick_a` at 0 and `tick_b` at 1. Edges on the source that is not selected are not counted.
- R6: A write to the wide timer's low register (address 2) loads only the holding buffer and leaves the counter unchanged. A write to the high register (address 3) loads the counter and its preload with {written byte, buffer}.
- R7: A read of address 3 returns the live counter high byte and copies the live low byte into the buffer. A read of address 2 returns the buffer, never the live count.
- R8: With control bit 7 set, the wide timer counts edges of `ext_cnt` after a two-stage synchronizer, one count for each selected edge of the pin.
- R9: Flags are set whatever the mask. A flag stays set until software writes 1 to its bit at address 4. Writing 0 leaves it set.
- R10: `irq` is high exactly when some flag is set whose mask bit (address 5, bit 0 narrow, bit 1 wide) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers the high-byte snapshot) |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| tick_a | input | 1 | Internal count source A, synchronous level |
| tick_b | input | 1 | Internal count source B, synchronous level |
| ext_cnt | input | 1 | Asynchronous external count pin |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the tick inputs are already synchronous to `clk`. They also assume that `wr_en` and `rd_en` select a single address each cycle, and that counting is enabled only when the selected source is quiet across a change of control bits. The stimulus drives every input just after a rising edge and holds each tick or pin level for four clocks, which is longer than the synchronizer plus edge-detector latency. It changes the control register only while all count sources are low, so no spurious edge reaches a counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_CTRL = 3'd0,
      RA_T0   = 3'd1,
      RA_T1L  = 3'd2,
      RA_T1H  = 3'd3,
      RA_FLAG = 3'd4,
      RA_MASK = 3'd5
   } reg_addr_e;

   // Control byte, MSB first
   typedef struct packed {
      logic t1_ext;
      logic t1_src;
      logic t1_fall;
      logic t1_en;
      logic rsvd;
      logic t0_src;
      logic t0_fall;
      logic t0_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign dout = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic fall_sel,
   output logic pulse
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign pulse = fall_sel ? (prev_q & ~sig) : (sig & ~prev_q);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic [W-1:0] pre_q;

   assign wrap = en & step & ~load & (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pre_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
         pre_q <= load_val;
      end else if (en && step) begin
         cnt_q <= (cnt_q == TOP) ? pre_q : cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/dual_timer.sv
module dual_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int T0_W      = 8,
   parameter int T1_W      = 16,
   parameter int EXT_SYNC  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic                  tick_a,
   input  logic                  tick_b,
   input  logic                  ext_cnt,
   output logic                  irq
);

   localparam int NTMR = 2;

   generate
      if (DATA_W != CTRL_W) begin : g_bad_data
         $error("dual_timer: DATA_W must equal the control byte width");
      end
      if (T0_W < 2 || T0_W > DATA_W) begin : g_bad_t0
         $error("dual_timer: T0_W must lie in 2..DATA_W");
      end
      if (T1_W != 2 * DATA_W) begin : g_bad_t1
         $error("dual_timer: T1_W must be twice DATA_W");
      end
      if (EXT_SYNC < 2) begin : g_bad_sync
         $error("dual_timer: EXT_SYNC needs at least two stages");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [NTMR-1:0]   flag_q;
   logic [NTMR-1:0]   mask_q;
   logic [DATA_W-1:0] lo_buf_q;

   logic wr_ctrl, wr_t0, wr_t1l, wr_t1h, wr_flag, wr_mask, rd_t1h;
   assign wr_ctrl = wr_en && (addr == RA_CTRL);
   assign wr_t0   = wr_en && (addr == RA_T0);
   assign wr_t1l  = wr_en && (addr == RA_T1L);
   assign wr_t1h  = wr_en && (addr == RA_T1H);
   assign wr_flag = wr_en && (addr == RA_FLAG);
   assign wr_mask = wr_en && (addr == RA_MASK);
   assign rd_t1h  = rd_en && (addr == RA_T1H);

   logic t0_run, t1_run;
   assign t0_run = ctrl_q.t0_en;
   assign t1_run = ctrl_q.t1_en;

   // ---------------- timer 0 ----------------
   logic            t0_raw, t0_step, t0_wrap;
   logic [T0_W-1:0] t0_cnt;

   assign t0_raw = ctrl_q.t0_src ? tick_b : tick_a;

   tmr_edge u_t0_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig      (t0_raw),
      .fall_sel (ctrl_q.t0_fall),
      .pulse    (t0_step)
   );

   tmr_counter #(.W(T0_W)) u_t0_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (t0_run),
      .step     (t0_step),
      .load     (wr_t0),
      .load_val (wdata[T0_W-1:0]),
      .cnt      (t0_cnt),
      .wrap     (t0_wrap)
   );

   // ---------------- timer 1 ----------------
   logic            ext_s, t1_int, t1_raw, t1_step, t1_wrap;
   logic [T1_W-1:0] t1_cnt;

   tmr_sync #(.STAGES(EXT_SYNC)) u_ext_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_cnt),
      .dout  (ext_s)
   );

   assign t1_int = ctrl_q.t1_src ? tick_b : tick_a;
   assign t1_raw = ctrl_q.t1_ext ? ext_s : t1_int;

   tmr_edge u_t1_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig      (t1_raw),
      .fall_sel (ctrl_q.t1_fall),
      .pulse    (t1_step)
   );

   tmr_counter #(.W(T1_W)) u_t1_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (t1_run),
      .step     (t1_step),
      .load     (wr_t1h),
      .load_val ({wdata, lo_buf_q}),
      .cnt      (t1_cnt),
      .wrap     (t1_wrap)
   );

   // ---------------- registers ----------------
   logic [NTMR-1:0] wrap_vec;
   logic [NTMR-1:0] clr_vec;
   assign wrap_vec = {t1_wrap, t0_wrap};
   assign clr_vec  = wr_flag ? wdata[NTMR-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         flag_q   <= '0;
         mask_q   <= '1;
         lo_buf_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q      <= ctrl_t'(wdata);
            ctrl_q.rsvd <= 1'b0;
         end
         if (wr_mask) mask_q <= wdata[NTMR-1:0];
         // a new overflow beats a clear in the same cycle
         flag_q <= (flag_q & ~clr_vec) | wrap_vec;
         if (wr_t1l)      lo_buf_q <= wdata;
         else if (rd_t1h) lo_buf_q <= t1_cnt[DATA_W-1:0];
      end
   end

   always_comb begin
      unique case (addr)
         RA_CTRL: rdata = DATA_W'(ctrl_q);
         RA_T0:   rdata = DATA_W'(t0_cnt);
         RA_T1L:  rdata = lo_buf_q;
         RA_T1H:  rdata = t1_cnt[T1_W-1:DATA_W];
         RA_FLAG: rdata = DATA_W'(flag_q);
         RA_MASK: rdata = DATA_W'(mask_q);
         default: rdata = '0;
      endcase
   end

   assign irq = |(flag_q & ~mask_q);

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int T0_W   = 8,
   parameter int T1_W   = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [REG_ADDR_W-1:0] addr,
   input logic [DATA_W-1:0]     wdata,
   input logic                  t0_run,
   input logic                  t1_run,
   input logic [T0_W-1:0]       t0_cnt,
   input logic [T1_W-1:0]       t1_cnt,
   input logic [1:0]            flags,
   input logic [1:0]            mask,
   input logic                  irq
);

   assert_t0_wrap_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> ($past(t0_cnt) == {T0_W{1'b1}}));

   assert_t1_wrap_at_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[1]) |-> ($past(t1_cnt) == {T1_W{1'b1}}));

   assert_t0_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!t0_run && !(wr_en && addr == RA_T0)) |=> $stable(t0_cnt));

   assert_lowwrite_no_count_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_T1L && !t1_run) |=> $stable(t1_cnt));

   assert_flag0_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(wr_en && addr == RA_FLAG && wdata[0])) |=> flags[0]);

   assert_flag1_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[1] && !(wr_en && addr == RA_FLAG && wdata[1])) |=> flags[1]);

   assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 2'b11) |-> !irq);

endmodule

bind dual_timer dual_timer_chk #(
   .DATA_W (DATA_W),
   .T0_W   (T0_W),
   .T1_W   (T1_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .t0_run (t0_run),
   .t1_run (t1_run),
   .t0_cnt (t0_cnt),
   .t1_cnt (t1_cnt),
   .flags  (flag_q),
   .mask   (mask_q),
   .irq    (irq)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tick_a = 1'b0;
   logic       tick_b = 1'b0;
   logic       ext_cnt = 1'b0;
   logic       irq;
   logic       irq_chk = 1'b0;

   always #2.5 clk = ~clk;

   dual_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_a(tick_a), .tick_b(tick_b),
      .ext_cnt(ext_cnt), .irq(irq)
   );

   typedef struct {
      bit         is_irq;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;

   // monitor: compares each strobed result against the scoreboard
   always @(negedge clk) begin
      if (rd_en || irq_chk) begin
         item_t it;
         logic [7:0] act;
         if (sb_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: result with no expected item");
         end else begin
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq} : rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b0; it.exp = e; it.req = r;
      sb_q.push_back(it);
      rd_en = 1'b1; addr = a;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string r);
      item_t it;
      @(posedge clk); #1;
      it.is_irq = 1'b1; it.exp = {7'b0, e}; it.req = r;
      sb_q.push_back(it);
      irq_chk = 1'b1;
      @(posedge clk); #1;
      irq_chk = 1'b0;
   endtask

   // which: 0 tick_a, 1 tick_b, 2 ext_cnt
   task automatic pulse(input int which);
      @(posedge clk); #1;
      if (which == 0) tick_a = 1'b1; else if (which == 1) tick_b = 1'b1; else ext_cnt = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      if (which == 0) tick_a = 1'b0; else if (which == 1) tick_b = 1'b0; else ext_cnt = 1'b0;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, 8'h00, "R1 ctrl");
      rd(3'd1, 8'h00, "R1 t0");
      rd(3'd3, 8'h00, "R1 t1 high");
      rd(3'd4, 8'h00, "R1 flags");
      rd(3'd5, 8'h03, "R1 mask");
      chk_irq(1'b0, "R1 irq");

      // R2 count, wrap, reload
      wr(3'd1, 8'hFD);
      wr(3'd0, 8'h01);
      pulse(0);
      rd(3'd1, 8'hFE, "R2 one step");
      pulse(0); pulse(0);
      rd(3'd1, 8'hFD, "R2 reload after wrap");
      rd(3'd4, 8'h01, "R2 flag0 set");
      chk_irq(1'b0, "R9 flag set while masked, irq low");
      wr(3'd5, 8'h02);
      chk_irq(1'b1, "R10 unmasked flag0 raises irq");
      wr(3'd4, 8'h00);
      rd(3'd4, 8'h01, "R9 write 0 keeps flag");
      wr(3'd4, 8'h01);
      rd(3'd4, 8'h00, "R9 write 1 clears flag");
      chk_irq(1'b0, "R10 irq low after clear");

      // R3 freeze and resume
      wr(3'd0, 8'h00);
      pulse(0);
      rd(3'd1, 8'hFD, "R3 disabled holds");
      wr(3'd0, 8'h01);
      pulse(0);
      rd(3'd1, 8'hFE, "R3 resumes from held value");

      // R4 falling edge
      wr(3'd0, 8'h03);
      pulse(0);
      rd(3'd1, 8'hFF, "R4 one count per falling edge");
      rd(3'd4, 8'h00, "R4 no wrap yet");

      // R5 source select
      wr(3'd0, 8'h05);
      pulse(0);
      rd(3'd1, 8'hFF, "R5 unselected source ignored");
      pulse(1);
      rd(3'd1, 8'hFD, "R5 tick_b counted and wrapped");
      rd(3'd4, 8'h01, "R2 flag0 after tick_b wrap");
      wr(3'd4, 8'h01);

      // R6 / R7 buffered wide access
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h34);
      rd(3'd2, 8'h34, "R7 low read returns buffer");
      rd(3'd3, 8'h00, "R6 low write leaves counter");
      rd(3'd2, 8'h00, "R7 high read latched live low");
      wr(3'd2, 8'hFE);
      wr(3'd3, 8'hFF);
      rd(3'd3, 8'hFF, "R6 high write commits high");
      rd(3'd2, 8'hFE, "R6 high write commits buffered low");

      // R8 external pin
      wr(3'd0, 8'h90);
      pulse(2);
      rd(3'd3, 8'hFF, "R8 ext high");
      rd(3'd2, 8'hFF, "R8 ext one count");
      pulse(2);
      rd(3'd3, 8'hFF, "R2 t1 reload high");
      rd(3'd2, 8'hFE, "R2 t1 reload low");
      rd(3'd4, 8'h02, "R9 flag1 set");
      chk_irq(1'b0, "R10 flag1 masked");
      wr(3'd5, 8'h01);
      chk_irq(1'b1, "R10 flag1 unmasked");
      wr(3'd4, 8'h02);
      chk_irq(1'b0, "R10 irq low after flag1 clear");

      // R8 + R4 external falling edge
      wr(3'd0, 8'hB0);
      pulse(2);
      rd(3'd3, 8'hFF, "R8 falling ext high");
      rd(3'd2, 8'hFF, "R8 falling ext one count");

      repeat (3) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard: %0d items never compared", sb_q.size());
      end
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule